// File: doc/BRIEF.md
# Bit-Serial Modbus RTU Check-Value Engine

This block computes the 16-bit check value that protects Modbus RTU messages. Data bytes arrive one at a time over a valid/ready handshake. A start flag that travels with a byte makes the engine load the all-ones preset before that byte is used. Each accepted byte is first XORed into the low half of the remainder register. The register then takes eight right shifts, one per clock. After any shift that pushes a 1 out of the least significant bit, the register is XORed with the reflected generator 0xA001.

While a byte is in progress the engine holds its input closed. Once the byte is finished it raises a done flag. It shows the running remainder at all times, and it also presents that remainder as two bytes in the order they go on the line: low byte first, high byte second. Feeding those two bytes back in after the message brings the remainder to zero. A receiver uses that result to accept or reject a frame. Only data bits are ever presented, so framing bits play no part.

Top module: `crc16_serial_engine`

## Requirements
- R1: While rst_n is low, and after it is released until the first byte is accepted, crc_out is 0xFFFF, in_ready is 1 and byte_done is 0.
- R2: When a byte is accepted with in_start = 1, the remainder is reset to 0xFFFF before that byte is XORed in, whatever the earlier message left behind.
- R3: An accepted byte is XORed into bits 7:0 of the remainder. The remainder then takes eight right shifts with a 0 entering bit 15. After each shift whose outgoing bit 0 was 1, the remainder is XORed with 0xA001.
- R4: A byte is accepted at a rising edge where in_valid and in_ready are both 1. In_ready then stays 0 for exactly eight cycles. In_valid and in_data presented during those cycles have no effect.
- R5: Byte_done rises in the cycle after the eighth shift. It stays 1, and crc_out stays unchanged, until the next byte is accepted. It falls in the cycle after that acceptance.
- R6: Tx_first carries bits 7:0 of the remainder and tx_second carries bits 15:8. This is the order in which they are transmitted.
- R7: The nine ASCII bytes "123456789", sent starting with in_start = 1, give the remainder 0x4B37 (tx_first = 0x37, tx_second = 0x4B).
- R8: Sending tx_first and then tx_second after a message, without in_start, leaves a remainder of 0x0000.
- R9: A byte accepted with in_start = 0 continues from the current remainder. A pulse on in_start without an accepted byte leaves the remainder unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Byte offered on in_data |
| in_data | input | 8 | Data byte |
| in_start | input | 1 | Offered byte is the first of a message; load the preset |
| in_ready | output | 1 | Engine can take a byte |
| crc_out | output | 16 | Running remainder |
| byte_done | output | 1 | Last accepted byte fully folded in |
| tx_first | output | 8 | Check byte sent first (remainder low byte) |
| tx_second | output | 8 | Check byte sent second (remainder high byte) |

## Verification
The hardest case to reach is a byte offered while the engine is busy shifting. The port never accepts it, so it can only show up as a corrupted remainder. The bench holds in_valid high with a different byte during the shift window, then releases it before in_ready returns. It then checks the remainder against the first byte alone. A near-exhaustive sweep covers every single byte from the preset and a 16-by-16 grid of two-byte continuations. The grid exercises the preset reload and remainder carry-over across byte boundaries.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int unsigned CHK_BYTE_W = 8;
  localparam int unsigned CHK_REM_W  = 16;
  localparam logic [15:0] CHK_POLY_REFL = 16'hA001;
  localparam logic [15:0] CHK_PRESET    = 16'hFFFF;
endpackage

// File: rtl/crc16_shift_step.sv
// One right shift of the remainder with conditional generator XOR.
module crc16_shift_step #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic          carry;
  logic [W-1:0]  shifted;

  assign carry   = cur[0];
  assign shifted = {1'b0, cur[W-1:1]};

  for (genvar k = 0; k < W; k++) begin : g_bit
    if (POLY[k]) begin : g_tap
      assign nxt[k] = shifted[k] ^ carry;
    end else begin : g_pass
      assign nxt[k] = shifted[k];
    end
  end
endmodule

// File: rtl/crc16_seq_ctrl.sv
// Handshake, shift counter and done flag.
module crc16_seq_ctrl #(
  parameter int unsigned STEPS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  output logic accept,
  output logic busy,
  output logic byte_done
);
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_step;

  assign in_ready  = !busy_q;
  assign accept    = in_valid && !busy_q;
  assign busy      = busy_q;
  assign byte_done = done_q;
  assign last_step = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last_step) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  // R4: acceptance closes the input for the shift window
  a_r4_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R5: done follows the final shift and input reopens
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q == LAST) |=> (byte_done && in_ready));
  // R5: done falls after a new acceptance
  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !byte_done);
endmodule

// File: rtl/crc16_rem_reg.sv
// Remainder register: byte load (with optional preset) and serial shift.
module crc16_rem_reg #(
  parameter int unsigned W  = 16,
  parameter int unsigned BW = 8,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          load_preset,
  input  logic [BW-1:0] din,
  input  logic          shift_en,
  output logic [W-1:0]  rem_q
);
  logic [W-1:0] base;
  logic [W-1:0] loaded;
  logic [W-1:0] stepped;
  logic [W-1:0] rem_d;

  assign base   = load_preset ? INIT : rem_q;
  assign loaded = {base[W-1:BW], base[BW-1:0] ^ din};

  crc16_shift_step #(.W(W), .POLY(POLY)) u_step (
    .cur (rem_q),
    .nxt (stepped)
  );

  always_comb begin
    rem_d = rem_q;
    if (load)          rem_d = loaded;
    else if (shift_en) rem_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= INIT;
    else        rem_q <= rem_d;
  end

  // R2: a preset load leaves the upper half at the preset value
  a_r2_preset_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_preset) |=> (rem_q[W-1:BW] == INIT[W-1:BW]));
  // R3: the top bit after a shift is the outgoing bit gated by the tap
  a_r3_shift_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load) |=> (rem_q[W-1] == ($past(rem_q[0]) & POLY[W-1])));
endmodule

// File: rtl/crc16_serial_engine.sv
module crc16_serial_engine
  import crc16_pkg::*;
#(
  parameter int unsigned BYTE_W = CHK_BYTE_W,
  parameter int unsigned REM_W  = CHK_REM_W,
  parameter logic [REM_W-1:0] POLY   = CHK_POLY_REFL,
  parameter logic [REM_W-1:0] PRESET = CHK_PRESET
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_start,
  output logic              in_ready,
  output logic [REM_W-1:0]  crc_out,
  output logic              byte_done,
  output logic [BYTE_W-1:0] tx_first,
  output logic [BYTE_W-1:0] tx_second
);
  logic accept;
  logic busy;

  crc16_seq_ctrl #(.STEPS(BYTE_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .accept    (accept),
    .busy      (busy),
    .byte_done (byte_done)
  );

  crc16_rem_reg #(.W(REM_W), .BW(BYTE_W), .POLY(POLY), .INIT(PRESET)) u_rem (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (accept),
    .load_preset (in_start),
    .din         (in_data),
    .shift_en    (busy),
    .rem_q       (crc_out)
  );

  assign tx_first  = crc_out[BYTE_W-1:0];
  assign tx_second = crc_out[REM_W-1:REM_W-BYTE_W];

  // R9: with no byte in flight and none accepted, the remainder holds
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(in_valid && in_ready)) |=> $stable(crc_out));
endmodule

// File: tb/tb_crc16_serial_engine.sv
module tb_crc16_serial_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_start;
  logic        in_ready;
  logic [15:0] crc_out;
  logic        byte_done;
  logic [7:0]  tx_first;
  logic [7:0]  tx_second;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  crc16_serial_engine dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_start(in_start), .in_ready(in_ready), .crc_out(crc_out),
    .byte_done(byte_done), .tx_first(tx_first), .tx_second(tx_second)
  );

  function automatic logic [15:0] model(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Sends one byte, returns the number of cycles in_ready was low.
  task automatic send(input logic [7:0] d, input logic st, output int low_cycles);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d; in_start = st;
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_data = 8'h00;
    low_cycles = 0;
    while (!in_ready) begin
      low_cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] exp;
    logic [7:0]  lo, hi;
    int          n;
    byte         msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_start = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 crc in reset", crc_out, 16'hFFFF);
    chk("R1 ready in reset", in_ready, 1);
    chk("R1 done in reset", byte_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 crc after release", crc_out, 16'hFFFF);
    chk("R1 done after release", byte_done, 0);

    // R3 R4 R5 R6: every single byte from the preset
    for (int d = 0; d < 256; d++) begin
      send(8'(d), 1'b1, n);
      exp = model(16'hFFFF, 8'(d));
      chk("R3 single byte", crc_out, exp);
      chk("R4 ready low cycles", n, 8);
      chk("R5 done after byte", byte_done, 1);
      chk("R6 tx_first", tx_first, exp[7:0]);
      chk("R6 tx_second", tx_second, exp[15:8]);
    end

    // R2 R9: two-byte grid, preset reload then continuation
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        send(8'(a * 17), 1'b1, n);
        send(8'(b * 13 + 5), 1'b0, n);
        exp = model(model(16'hFFFF, 8'(a * 17)), 8'(b * 13 + 5));
        chk("R9 continuation", crc_out, exp);
      end
    end

    // R7: standard check string
    for (int i = 0; i < 9; i++) send(msg[i], (i == 0), n);
    chk("R7 check string", crc_out, 16'h4B37);
    chk("R7 tx_first", tx_first, 8'h37);
    chk("R7 tx_second", tx_second, 8'h4B);
    lo = tx_first; hi = tx_second;

    // R5: done and remainder hold while idle
    repeat (5) @(negedge clk);
    chk("R5 done held", byte_done, 1);
    chk("R5 crc held", crc_out, 16'h4B37);

    // R8: append check bytes, low first
    send(lo, 1'b0, n);
    send(hi, 1'b0, n);
    chk("R8 residue zero", crc_out, 16'h0000);

    // R9: start pulse without a byte is ignored
    @(negedge clk);
    in_start = 1'b1;
    @(negedge clk);
    in_start = 1'b0;
    @(negedge clk);
    chk("R9 lone start ignored", crc_out, 16'h0000);

    // R2: start mid-stream reloads the preset
    send(8'hA5, 1'b0, n);
    send(8'h3C, 1'b1, n);
    chk("R2 reload mid-stream", crc_out, model(16'hFFFF, 8'h3C));

    // R4: bytes offered while busy are ignored
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h5A; in_start = 1'b1;
    @(negedge clk);
    in_data = 8'hC3; in_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R4 ready low while busy", in_ready, 0);
    while (!in_ready) @(negedge clk);
    chk("R4 busy offer ignored", crc_out, model(16'hFFFF, 8'h5A));

    // R5: done falls after the next acceptance
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h11; in_start = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R5 done cleared", byte_done, 0);
    while (!in_ready) @(negedge clk);

    // R1: reset mid-byte
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h77; in_start = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 crc mid reset", crc_out, 16'hFFFF);
    chk("R1 ready mid reset", in_ready, 1);
    chk("R1 done mid reset", byte_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule